// File: doc/BRIEF.md
# Slow-Clock Counter with Two Compare Channels

This block is an up-counter that runs on a slow clock. Two compare values are watched against the running count, and a single-cycle strobe fires on each channel when the counter reaches that value. The wrap point can be chosen at run time. One setting lets the counter run through its full binary range. The other makes compare channel 0 act as the ceiling, so that the counter returns to zero after it has reached that value. An overflow strobe marks the last cycle before each return to zero, in either setting.

A debug-halt input can freeze the count. A debug-run control decides whether that freeze applies. When the enable input is low, the counter is held at zero, so dropping enable and raising it again restarts the count from zero. A small read-back port returns either compare value by index, and returns zero for any index that names no channel. Interrupt masking, the bus interface and clock-domain crossing belong to neighbouring blocks.

Top module: `lf_cmp_counter`

## Requirements
- R1: After reset the count is zero and the strobes `cmp0_hit`, `cmp1_hit` and `wrap_evt` are low.
- R2: While `cnt_en` is low, the count becomes zero at the next clock edge and every strobe stays low. Dropping `cnt_en` and raising it again therefore restarts counting from zero.
- R3: A cycle is a tick when `cnt_en` is high and either `dbg_halt` is low or `dbg_keep_run` is high. In a cycle where `cnt_en` is high and no tick occurs, the count holds its value and every strobe stays low.
- R4: On a tick where the count is not at the wrap point, the count rises by one.
- R5: When `top_from_cmp0` is 0, the wrap point is the all-ones value (0xFFFFFF for the default 24-bit width). When `top_from_cmp0` is 1, the wrap point is `cmp0_val`. On a tick where the count equals the wrap point, the count becomes zero at the next edge.
- R6: `wrap_evt` is high exactly in tick cycles where the count equals the wrap point.
- R7: `cmp0_hit` is high exactly in tick cycles where the count equals `cmp0_val`. `cmp1_hit` is high exactly in tick cycles where the count equals `cmp1_val`.
- R8: When `top_from_cmp0` is 1 and `cmp0_val` is 0, the count stays at zero, and `cmp0_hit` and `wrap_evt` are high in every tick cycle.
- R9: `rd_val` is combinational. It returns `cmp0_val` when `rd_idx` is 0, returns `cmp1_val` when `rd_idx` is 1, and returns zero for `rd_idx` values 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable; the count is held at zero while low |
| dbg_keep_run | input | 1 | Keep counting while debug halt is asserted |
| dbg_halt | input | 1 | Debug halt request |
| top_from_cmp0 | input | 1 | Use compare 0 as the wrap point |
| cmp0_val | input | W (24) | Compare channel 0 value |
| cmp1_val | input | W (24) | Compare channel 1 value |
| rd_idx | input | 2 | Compare read-back index |
| rd_val | output | W (24) | Selected compare value, zero for an invalid index |
| count | output | W (24) | Current counter value |
| cmp0_hit | output | 1 | Compare 0 match strobe |
| cmp1_hit | output | 1 | Compare 1 match strobe |
| wrap_evt | output | 1 | Strobe in the last cycle before a wrap to zero |

## Verification
The hardest case to reach from the ports is the natural wrap with `top_from_cmp0` at 0. At 24 bits it would take about sixteen million ticks. The bench therefore builds the counter with a 10-bit width parameter and runs an uninterrupted full lap, so the all-ones wrap and its single overflow strobe are seen. Random stimulus keeps both compare values small and toggles halt, keep-run and the wrap mode. This makes matches, compare-defined wraps and held cycles frequent. Directed sequences cover a zero ceiling, an enable restart and invalid read-back indices.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic {
    WRAP_FULL  = 1'b0,
    WRAP_COMP0 = 1'b1
  } lfc_wrap_e;

  // A counting cycle: enabled, and either not halted or told to run through halt
  function automatic logic tick_ok(input logic en, input logic halt, input logic keep_run);
    return en && (!halt || keep_run);
  endfunction

endpackage

// File: rtl/lfc_tick_gate.sv
module lfc_tick_gate (
  input  logic             en,
  input  logic             halt,
  input  logic             keep_run,
  input  logic             top_sel,
  output logic             tick,
  output lfc_pkg::lfc_wrap_e mode
);
  import lfc_pkg::*;

  always_comb begin
    tick = tick_ok(en, halt, keep_run);
    mode = top_sel ? WRAP_COMP0 : WRAP_FULL;
  end

endmodule

// File: rtl/lfc_count_core.sv
module lfc_count_core #(
  parameter int W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  lfc_pkg::lfc_wrap_e mode,
  input  logic [W-1:0]       ceil_cmp,
  output logic [W-1:0]       cnt,
  output logic               at_top
);
  import lfc_pkg::*;

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] top_val;
  logic [W-1:0] cnt_nxt;

  function automatic logic [W-1:0] pick_top(input lfc_wrap_e m, input logic [W-1:0] c0);
    return (m == WRAP_COMP0) ? c0 : ALL_ONES;
  endfunction

  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic [W-1:0] top);
    return (cur == top) ? '0 : cur + ONE;
  endfunction

  always_comb begin
    top_val = pick_top(mode, ceil_cmp);
    at_top  = tick && (cnt == top_val);
    if (!en)       cnt_nxt = '0;
    else if (tick) cnt_nxt = step(cnt, top_val);
    else           cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/lfc_match_unit.sv
module lfc_match_unit #(
  parameter int W     = 24,
  parameter int N     = 2,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0][W-1:0] cmp_vals,
  input  logic [W-1:0]        cnt,
  input  logic                tick,
  input  logic [SEL_W-1:0]    sel,
  output logic [N-1:0]        hit,
  output logic [W-1:0]        rd
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = tick && (cnt == cmp_vals[g]);
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) rd = cmp_vals[i];
    end
  end

endmodule

// File: rtl/lf_cmp_counter.sv
module lf_cmp_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         dbg_keep_run,
  input  logic         dbg_halt,
  input  logic         top_from_cmp0,
  input  logic [W-1:0] cmp0_val,
  input  logic [W-1:0] cmp1_val,
  input  logic [1:0]   rd_idx,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] count,
  output logic         cmp0_hit,
  output logic         cmp1_hit,
  output logic         wrap_evt
);
  import lfc_pkg::*;

  localparam int NCMP = 2;

  logic                   tick_w;
  lfc_wrap_e              mode_w;
  logic [NCMP-1:0][W-1:0] cmp_arr;
  logic [NCMP-1:0]        hit_w;

  assign cmp_arr[0] = cmp0_val;
  assign cmp_arr[1] = cmp1_val;

  lfc_tick_gate u_gate (
    .en       (cnt_en),
    .halt     (dbg_halt),
    .keep_run (dbg_keep_run),
    .top_sel  (top_from_cmp0),
    .tick     (tick_w),
    .mode     (mode_w)
  );

  lfc_count_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cnt_en),
    .tick     (tick_w),
    .mode     (mode_w),
    .ceil_cmp (cmp0_val),
    .cnt      (count),
    .at_top   (wrap_evt)
  );

  lfc_match_unit #(.W(W), .N(NCMP), .SEL_W(2)) u_match (
    .cmp_vals (cmp_arr),
    .cnt      (count),
    .tick     (tick_w),
    .sel      (rd_idx),
    .hit      (hit_w),
    .rd       (rd_val)
  );

  assign cmp0_hit = hit_w[0];
  assign cmp1_hit = hit_w[1];

endmodule

// File: rtl/lf_cmp_counter_chk.sv
module lf_cmp_counter_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         dbg_keep_run,
  input logic         dbg_halt,
  input logic         top_from_cmp0,
  input logic [W-1:0] cmp0_val,
  input logic [1:0]   rd_idx,
  input logic [W-1:0] rd_val,
  input logic [W-1:0] count,
  input logic         cmp0_hit,
  input logic         cmp1_hit,
  input logic         wrap_evt,
  input logic         tick_w
);

  // R2
  en_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (count == '0));

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && dbg_halt && !dbg_keep_run) |=> $stable(count));

  // R3
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_w |-> !(cmp0_hit || cmp1_hit || wrap_evt));

  // R4
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && !wrap_evt) |=> (count == $past(count) + W'(1)));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && cnt_en) |=> (count == '0));

  // R8
  zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_from_cmp0 && cmp0_val == '0 && tick_w && count == '0) |-> (cmp0_hit && wrap_evt));

  // R9
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > 2'd1) |-> (rd_val == '0));

endmodule

bind lf_cmp_counter lf_cmp_counter_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cnt_en        (cnt_en),
  .dbg_keep_run  (dbg_keep_run),
  .dbg_halt      (dbg_halt),
  .top_from_cmp0 (top_from_cmp0),
  .cmp0_val      (cmp0_val),
  .rd_idx        (rd_idx),
  .rd_val        (rd_val),
  .count         (count),
  .cmp0_hit      (cmp0_hit),
  .cmp1_hit      (cmp1_hit),
  .wrap_evt      (wrap_evt),
  .tick_w        (tick_w)
);

// File: tb/tb_lf_cmp_counter.sv
module tb_lf_cmp_counter;
  localparam int TW = 10;
  localparam logic [TW-1:0] MAXV = {TW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0, dbg_keep_run = 1'b0, dbg_halt = 1'b0, top_from_cmp0 = 1'b0;
  logic [TW-1:0] cmp0_val = '0, cmp1_val = '0;
  logic [1:0]    rd_idx = '0;
  logic [TW-1:0] rd_val, count;
  logic          cmp0_hit, cmp1_hit, wrap_evt;

  int n_chk = 0, n_fail = 0, n_wrap = 0;
  bit finished = 0;
  logic [TW-1:0] exp_cnt = '0;

  always #4 clk = ~clk;

  lf_cmp_counter #(.W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dbg_keep_run(dbg_keep_run),
    .dbg_halt(dbg_halt), .top_from_cmp0(top_from_cmp0), .cmp0_val(cmp0_val),
    .cmp1_val(cmp1_val), .rd_idx(rd_idx), .rd_val(rd_val), .count(count),
    .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit), .wrap_evt(wrap_evt)
  );

  function automatic bit m_tick();
    return cnt_en && (!dbg_halt || dbg_keep_run);
  endfunction

  function automatic logic [TW-1:0] m_top();
    return top_from_cmp0 ? cmp0_val : MAXV;
  endfunction

  function automatic logic [TW-1:0] m_next(input logic [TW-1:0] c);
    if (!cnt_en) return '0;
    if (!m_tick()) return c;
    if (c == m_top()) return '0;
    return c + 1'b1;
  endfunction

  function automatic logic [TW-1:0] m_rd();
    case (rd_idx)
      2'd0: return cmp0_val;
      2'd1: return cmp1_val;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven after a negedge
  task automatic step();
    #1;
    chk("R6 wrap_evt", int'(wrap_evt), int'(m_tick() && exp_cnt == m_top()));
    chk("R7 cmp0_hit", int'(cmp0_hit), int'(m_tick() && exp_cnt == cmp0_val));
    chk("R7 cmp1_hit", int'(cmp1_hit), int'(m_tick() && exp_cnt == cmp1_val));
    chk("R9 rd_val", int'(rd_val), int'(m_rd()));
    if (wrap_evt) n_wrap++;
    @(posedge clk);
    exp_cnt = m_next(exp_cnt);
    @(negedge clk);
    chk("R4/R5 count", int'(count), int'(exp_cnt));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 strobes", int'({cmp0_hit, cmp1_hit, wrap_evt}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 disabled: held at zero, no strobes
    cmp1_val = '0;
    repeat (3) step();
    chk("R2 held", int'(count), 0);

    // R5 full-range lap with no ceiling
    cnt_en = 1'b1; cmp0_val = 10'd5; cmp1_val = 10'd700;
    n_wrap = 0;
    repeat (1 << TW) step();
    chk("R5 full wrap once", n_wrap, 1);
    chk("R5 full wrap back to zero", int'(count), 0);

    // R8 zero ceiling
    top_from_cmp0 = 1'b1; cmp0_val = '0;
    repeat (5) begin
      step();
      chk("R8 stuck zero", int'(count), 0);
    end

    // R2 restart via enable drop
    cmp0_val = 10'd30; cmp1_val = 10'd12;
    repeat (17) step();
    cnt_en = 1'b0; step();
    chk("R2 restart low", int'(count), 0);
    cnt_en = 1'b1; step();
    chk("R2 restart count", int'(count), 1);

    // R3 halt holds without keep-run, runs with it
    dbg_halt = 1'b1; dbg_keep_run = 1'b0;
    repeat (4) step();
    chk("R3 held under halt", int'(count), 1);
    dbg_keep_run = 1'b1;
    repeat (3) step();
    chk("R3 keep-run counts", int'(count), 4);
    dbg_halt = 1'b0; dbg_keep_run = 1'b0;

    // R9 invalid indices
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      step();
    end

    // random mix
    for (int i = 0; i < 6000; i++) begin
      cnt_en        = ($urandom % 40) != 0;
      dbg_halt      = ($urandom % 5) == 0;
      dbg_keep_run  = ($urandom % 2) == 0;
      rd_idx        = 2'($urandom % 4);
      if (($urandom % 50) == 0) top_from_cmp0 = ~top_from_cmp0;
      if (($urandom % 60) == 0) cmp0_val = TW'($urandom % 40);
      if (($urandom % 60) == 0) cmp1_val = TW'($urandom % 48);
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule